// File: doc/BRIEF.md
# Raster Beam Timing and Line Report Generator

This block produces the beam position for a character-based video controller. Every chip-cycle enable advances a horizontal counter. When that counter wraps, a vertical counter advances. Together they sweep one field at a time.

The video standard is picked by a select input and is captured only while reset is held. The standard sets the line length, the field length and two raster-report positions. The NTSC standard can also run interlaced, alternating a short odd field with a long even field.

Alongside the beam position the block derives two signals:

- A field-parity flag and a vertical sync level.
- The line number that a processor would read back. This reported line runs ahead of the vertical counter by a fixed number of cycles. It has its own rule for the last line of a field.

Top module: `raster_timing_gen`

## Requirements
- R1: While `rst_n` is low and in the cycle after it rises, `hcount` = 0, `vcount` = 0, `raster` = 0 and `odd_field` = 1.
- R2: `hcount` advances by one on each clock with `chip_ce` = 1 and wraps to 0 after the last cycle of a line. The last cycle is 70 for PAL (`std_ntsc` = 0) and 64 for NTSC (`std_ntsc` = 1). With `chip_ce` = 0 neither counter changes.
- R3: `vcount` advances when `hcount` wraps, and returns to 0 after the last line of the field. A progressive field has 312 lines in PAL and 261 lines in NTSC.
- R4: In NTSC with `interlace_en` = 1, the first field after reset is odd (`odd_field` = 1) and has 262 lines. The next field is even and has 263 lines. Odd and even fields then alternate, and `odd_field` flips only at the field boundary.
- R5: Away from the field end, `raster` equals `vcount`. In NTSC, once `hcount` >= 25, `raster` equals `vcount` + 1 (a lead of 40 cycles). PAL has no lead.
- R6: On the last line of an odd field, or of any field with interlace off, a lead that would reach the field length instead holds `raster` at field length − 1. `raster` changes to 0 once `hcount` >= 58.
- R7: On the last line of an even field, `raster` becomes 0 as soon as the lead applies (`hcount` >= 25).
- R8: In PAL, `interlace_en` has no effect. Fields stay 312 lines and `odd_field` stays 1.
- R9: `vsync` is 1 while `vcount` < 3 on an odd field.
- R10: When interlaced, `vsync` is also 1 on line 0 while `hcount` > 32. This takes effect on even fields.
- R11: A change of `std_ntsc` after reset has no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the standard is captured while it is low |
| chip_ce | input | 1 | One chip cycle when 1 |
| std_ntsc | input | 1 | 0 = PAL timing, 1 = NTSC timing |
| interlace_en | input | 1 | Request interlaced fields (NTSC only) |
| hcount | output | 7 | Horizontal cycle within the line |
| vcount | output | 9 | Line within the field |
| odd_field | output | 1 | 1 on an odd field, or always when not interlaced |
| vsync | output | 1 | Vertical sync level |
| raster | output | 9 | Line number reported to the processor |

## Verification
The bench goes after the last line of each field kind:

- **Progressive NTSC last line.** The bench checks that `raster` holds at 260 until cycle 58. A design that wrapped at the lead point would show 0 from cycle 25. A design that did not wrap would show 261.
- **Interlaced last lines.** The bench checks both field lengths (262 and 263) and the early wrap on the even field. A design that applied the odd-field hold there would report 262 instead of 0.
- **Ignored inputs.** PAL runs with interlace requested, and an NTSC run has the select flipped after reset. A design that honoured either input would show a wrong line length or a wrong parity.

// File: rtl/raster_pkg.sv
// Package: shared widths, timing record and per-standard constants for
// the raster timing generator. Assumes line and field lengths fit in
// VC_W bits and the line length fits in HC_W bits.
package raster_pkg;

    localparam int HC_W = 7;
    localparam int VC_W = 9;

    typedef logic [VC_W-1:0] line_t;

    // Timing set selected by the video standard.
    typedef struct packed {
        line_t cpl;        // cycles per line
        line_t lead;       // cycles the reported line runs ahead
        line_t wrap_pos;   // cycle where an odd-field last line reports 0
        line_t prog_lines; // lines in a progressive field
    } timing_t;

    localparam line_t ILACE_ODD_LINES  = line_t'(262);
    localparam line_t ILACE_EVEN_LINES = line_t'(263);
    localparam line_t VSYNC_LINES      = line_t'(3);
    localparam line_t VSYNC_HALF_POS   = line_t'(32);

    // Return the timing set for the chosen standard.
    function automatic timing_t timing_for(input logic ntsc);
        timing_t t;
        if (ntsc) begin
            t.cpl        = line_t'(65);
            t.lead       = line_t'(40);
            t.wrap_pos   = line_t'(58);
            t.prog_lines = line_t'(261);
        end else begin
            t.cpl        = line_t'(71);
            t.lead       = line_t'(0);
            t.wrap_pos   = line_t'(71);
            t.prog_lines = line_t'(312);
        end
        return t;
    endfunction

endpackage

// File: rtl/raster_std_cfg.sv
// Module: captures the video-standard select while reset is low and
// presents the matching timing set. Interlace is only honoured for the
// standard that supports it. Assumes the select is settled during reset.
module raster_std_cfg
    import raster_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    std_ntsc,
    input  logic    interlace_en,
    output timing_t tcfg,
    output logic    ilace_eff
);

    logic ntsc_q;

    // Sample the standard only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ntsc_q <= std_ntsc;
        end
    end

    // Derive timing constants and effective interlace from the stored standard.
    always_comb begin
        tcfg      = timing_for(ntsc_q);
        ilace_eff = interlace_en & ntsc_q;
    end

endmodule

// File: rtl/raster_beam_counter.sv
// Module: horizontal and vertical beam counters plus field parity.
// Each enable advances the horizontal counter; its wrap advances the
// vertical counter, whose wrap ends the field and flips parity when
// interlaced. Assumes the timing set is constant outside reset.
module raster_beam_counter
    import raster_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            chip_ce,
    input  timing_t         tcfg,
    input  logic            ilace_eff,
    output logic [HC_W-1:0] h_q,
    output line_t           v_q,
    output logic            odd_eff,
    output line_t           field_len
);

    logic  field_odd_q;
    logic  h_last;
    logic  v_last;

    // Parity and current field length.
    always_comb begin
        odd_eff   = field_odd_q | ~ilace_eff;
        if (ilace_eff) begin
            field_len = odd_eff ? ILACE_ODD_LINES : ILACE_EVEN_LINES;
        end else begin
            field_len = tcfg.prog_lines;
        end
        h_last = (line_t'(h_q) == tcfg.cpl - line_t'(1));
        v_last = (v_q >= field_len - line_t'(1));
    end

    // Advance the beam position and field parity on each chip cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_q         <= '0;
            v_q         <= '0;
            field_odd_q <= 1'b1;
        end else if (chip_ce) begin
            if (h_last) begin
                h_q <= '0;
                if (v_last) begin
                    v_q <= '0;
                    if (ilace_eff) begin
                        field_odd_q <= ~field_odd_q;
                    end
                end else begin
                    v_q <= v_q + line_t'(1);
                end
            end else begin
                h_q <= h_q + HC_W'(1);
            end
        end
    end

endmodule

// File: rtl/raster_line_report.sv
// Module: reported line number. Adds one line once the horizontal
// position plus the lead reaches a line length, and applies the
// field-end rule: odd fields hold the last line until the wrap
// position, even fields go straight to zero. Assumes vcount stays below
// the field length.
module raster_line_report
    import raster_pkg::*;
(
    input  logic [HC_W-1:0] h_q,
    input  line_t           v_q,
    input  timing_t         tcfg,
    input  logic            odd_eff,
    input  line_t           field_len,
    output line_t           raster
);

    logic [VC_W:0] lead_sum;
    logic [VC_W:0] line_raw;
    logic          bonus;

    // Compute the ahead-of-time line and fold it at the field end.
    always_comb begin
        lead_sum = {1'b0, line_t'(h_q)} + {1'b0, tcfg.lead};
        bonus    = (lead_sum >= {1'b0, tcfg.cpl});
        line_raw = {1'b0, v_q} + {{VC_W{1'b0}}, bonus};
        if (line_raw < {1'b0, field_len}) begin
            raster = line_raw[VC_W-1:0];
        end else if (odd_eff) begin
            raster = (line_t'(h_q) >= tcfg.wrap_pos) ? '0 : field_len - line_t'(1);
        end else begin
            raster = '0;
        end
    end

endmodule

// File: rtl/raster_vsync_gen.sv
// Module: vertical sync level. Asserted on the first lines of an odd
// field, and in interlaced mode also on the second half of line 0.
module raster_vsync_gen
    import raster_pkg::*;
(
    input  logic [HC_W-1:0] h_q,
    input  line_t           v_q,
    input  logic            odd_eff,
    input  logic            ilace_eff,
    output logic            vsync
);

    // Combine the whole-line and half-line sync windows.
    always_comb begin
        vsync = ((v_q < VSYNC_LINES) && odd_eff) ||
                (ilace_eff && (v_q == '0) && (line_t'(h_q) > VSYNC_HALF_POS));
    end

endmodule

// File: rtl/raster_timing_gen.sv
// Module: top of the raster timing generator. Ties the standard capture,
// beam counters, line report and sync generator together. Assumes the
// standard and interlace selects only change while reset is low.
module raster_timing_gen
    import raster_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            chip_ce,
    input  logic            std_ntsc,
    input  logic            interlace_en,
    output logic [HC_W-1:0] hcount,
    output logic [VC_W-1:0] vcount,
    output logic            odd_field,
    output logic            vsync,
    output logic [VC_W-1:0] raster
);

    timing_t tcfg;
    logic    ilace_eff;
    line_t   field_len;
    line_t   v_int;
    logic    odd_int;

    raster_std_cfg u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .std_ntsc     (std_ntsc),
        .interlace_en (interlace_en),
        .tcfg         (tcfg),
        .ilace_eff    (ilace_eff)
    );

    raster_beam_counter u_beam (
        .clk       (clk),
        .rst_n     (rst_n),
        .chip_ce   (chip_ce),
        .tcfg      (tcfg),
        .ilace_eff (ilace_eff),
        .h_q       (hcount),
        .v_q       (v_int),
        .odd_eff   (odd_int),
        .field_len (field_len)
    );

    raster_line_report u_line (
        .h_q       (hcount),
        .v_q       (v_int),
        .tcfg      (tcfg),
        .odd_eff   (odd_int),
        .field_len (field_len),
        .raster    (raster)
    );

    raster_vsync_gen u_vs (
        .h_q       (hcount),
        .v_q       (v_int),
        .odd_eff   (odd_int),
        .ilace_eff (ilace_eff),
        .vsync     (vsync)
    );

    // Drive the visible line and parity.
    always_comb begin
        vcount    = v_int;
        odd_field = odd_int;
    end

endmodule

// File: rtl/raster_timing_chk.sv
// Checker: temporal properties of the raster timing generator, bound to
// the top module. Observes ports only.
module raster_timing_chk
    import raster_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            chip_ce,
    input logic [HC_W-1:0] hcount,
    input logic [VC_W-1:0] vcount,
    input logic            odd_field,
    input logic            vsync,
    input logic [VC_W-1:0] raster
);

    // R2
    ce_low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_ce |=> ($stable(hcount) && $stable(vcount)));

    // R2
    h_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chip_ce |=> ((hcount == $past(hcount) + HC_W'(1)) || (hcount == '0)));

    // R3
    v_moves_on_h_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vcount) |-> (hcount == '0));

    // R4
    parity_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(odd_field) |-> ((vcount == '0) && (hcount == '0)));

    // R5
    raster_near_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raster == vcount) || (raster == vcount + 9'd1) || (raster == '0));

    // R9
    vsync_odd_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (odd_field && (vcount < 9'd3)) |-> vsync);

    // R10
    vsync_even_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!odd_field && (vcount == '0) && (hcount > 7'd32)) |-> vsync);

endmodule

bind raster_timing_gen raster_timing_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chip_ce   (chip_ce),
    .hcount    (hcount),
    .vcount    (vcount),
    .odd_field (odd_field),
    .vsync     (vsync),
    .raster    (raster)
);

// File: tb/sim_raster_timing_gen.sv
// Scoreboard bench: driver tasks advance a reference model and push the
// expected port values; a monitor pops and compares at each falling edge.
module sim_raster_timing_gen;

    typedef struct packed {
        logic [6:0] h;
        logic [8:0] v;
        logic       odd;
        logic       vs;
        logic [8:0] ras;
        logic [8:0] flen;
        logic [7:0] scn;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chip_ce = 1'b0;
    logic       std_ntsc = 1'b0;
    logic       interlace_en = 1'b0;
    logic [6:0] hcount;
    logic [8:0] vcount;
    logic       odd_field;
    logic       vsync;
    logic [8:0] raster;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    exp_t q[$];

    // reference model state
    int  m_cpl, m_lead, m_wpos, m_prog;
    int  mh, mv;
    bit  m_ntsc, m_ilace, m_odd_q;
    int  cur_scn;

    raster_timing_gen u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .chip_ce      (chip_ce),
        .std_ntsc     (std_ntsc),
        .interlace_en (interlace_en),
        .hcount       (hcount),
        .vcount       (vcount),
        .odd_field    (odd_field),
        .vsync        (vsync),
        .raster       (raster)
    );

    always #5 clk = ~clk;

    function automatic bit m_odd();
        return m_odd_q || !m_ilace;
    endfunction

    function automatic int m_len();
        if (m_ilace) return m_odd() ? 262 : 263;
        return m_prog;
    endfunction

    // Expected reported line: absolute cycle position plus lead, in lines.
    function automatic int m_raster();
        int pos;
        int ln;
        pos = mv * m_cpl + mh + m_lead;
        ln  = pos / m_cpl;
        if (ln < m_len()) return ln;
        if (m_odd()) return (mh >= m_wpos) ? 0 : m_len() - 1;
        return 0;
    endfunction

    function automatic bit m_vsync();
        return (mv < 3 && m_odd()) || (m_ilace && mv == 0 && mh > 32);
    endfunction

    task automatic push_exp();
        exp_t e;
        e.h    = 7'(mh);
        e.v    = 9'(mv);
        e.odd  = m_odd();
        e.vs   = m_vsync();
        e.ras  = 9'(m_raster());
        e.flen = 9'(m_len());
        e.scn  = 8'(cur_scn);
        q.push_back(e);
    endtask

    // Reset with a given standard and interlace request; checks R1 after.
    task automatic do_reset(input bit ntsc, input bit ilace);
        @(negedge clk);
        rst_n = 1'b0;
        chip_ce = 1'b0;
        std_ntsc = ntsc;
        interlace_en = ilace;
        repeat (3) @(posedge clk);
        m_ntsc  = ntsc;
        m_ilace = ilace && ntsc;
        m_cpl   = ntsc ? 65 : 71;
        m_lead  = ntsc ? 40 : 0;
        m_wpos  = ntsc ? 58 : 71;
        m_prog  = ntsc ? 261 : 312;
        mh = 0; mv = 0; m_odd_q = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        cur_scn = 1; // R1 reset state
        push_exp();
    endtask

    // One enabled chip cycle.
    task automatic step();
        @(negedge clk);
        chip_ce = 1'b1;
        @(posedge clk);
        #1;
        chip_ce = 1'b0;
        if (mh == m_cpl - 1) begin
            mh = 0;
            if (mv == m_len() - 1) begin
                mv = 0;
                if (m_ilace) m_odd_q = !m_odd_q;
            end else begin
                mv = mv + 1;
            end
        end else begin
            mh = mh + 1;
        end
        push_exp();
    endtask

    // One cycle with the enable low: nothing may move (R2).
    task automatic idle();
        @(negedge clk);
        chip_ce = 1'b0;
        @(posedge clk);
        #1;
        push_exp();
    endtask

    function automatic string scn_name(input logic [7:0] s);
        case (s)
            8'd1:  return "R1";
            8'd8:  return "R8";
            8'd11: return "R11";
            default: return "-";
        endcase
    endfunction

    task automatic cmp(input string req, input int act, input int exp_v, input logic [7:0] s);
        checks++;
        if (act != exp_v) begin
            fails++;
            $display("FAIL %s (scenario %s) at t=%0t: actual %0d expected %0d",
                     req, scn_name(s), $time, act, exp_v);
        end
    endtask

    // Monitor: compare every expected item away from the active edge.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            string rtag;
            string vtag;
            e = q.pop_front();
            rtag = "R5";
            if (32'(e.v) == 32'(e.flen) - 1 && e.ras != e.v) rtag = e.odd ? "R6" : "R7";
            vtag = (e.v == 0 && e.h > 32 && !e.odd) ? "R10" : "R9";
            if (e.scn == 8'd1) begin
                cmp("R1", hcount, e.h, e.scn);
                cmp("R1", vcount, e.v, e.scn);
                cmp("R1", odd_field, e.odd, e.scn);
                cmp("R1", raster, e.ras, e.scn);
            end else begin
                cmp(e.scn == 8'd11 ? "R11" : "R2", hcount, e.h, e.scn);
                cmp(e.scn == 8'd8 ? "R8" : "R3", vcount, e.v, e.scn);
                cmp(e.scn == 8'd8 ? "R8" : "R4", odd_field, e.odd, e.scn);
                cmp(rtag, raster, e.ras, e.scn);
                cmp(vtag, vsync, e.vs, e.scn);
            end
        end
    end

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run incomplete, actual timeout expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        cur_scn = 0;
        // R1, R2, R3, R9: PAL progressive with enable gaps
        do_reset(1'b0, 1'b0);
        cur_scn = 0;
        repeat (3) idle();
        repeat (312 * 71 + 80) step();

        // R8: PAL with interlace requested
        do_reset(1'b0, 1'b1);
        cur_scn = 8;
        repeat (312 * 71 + 80) step();

        // R5, R6: NTSC progressive, last-line hold then wrap at 58
        do_reset(1'b1, 1'b0);
        cur_scn = 0;
        repeat (261 * 65 + 80) step();

        // R4, R7, R10: NTSC interlaced across both field kinds
        do_reset(1'b1, 1'b1);
        cur_scn = 0;
        for (int i = 0; i < 525 * 65 + 80; i++) begin
            step();
            if (i % 997 == 0) idle();
        end

        // R11: select flipped after reset must not change line length
        do_reset(1'b1, 1'b0);
        cur_scn = 11;
        @(negedge clk);
        std_ntsc = 1'b0;
        repeat (3 * 65 + 10) step();

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule